// File: doc/BRIEF.md
# Multi-Mode Serial Clock Generator

This block produces the timing pulses that a serial transmitter and receiver run on. A 12-bit divisor sets the rate of a down-counting baud divider. Three select inputs choose one of four clocking schemes. In the two asynchronous schemes the divider output becomes the receiver's oversample tick. Every 16th tick (normal rate) or every 8th tick (double rate) also becomes the transmitter's bit tick.

In the synchronous schemes a transfer clock sets the bit timing. As master, the block drives that clock itself and toggles it on every divider tick. As slave, it takes the clock from a pin and passes it through a synchronizer, and each edge of the synchronized clock gives one pulse. The pin driver is enabled only in master synchronous operation. Frame shifting and data handling belong to the neighbouring shift logic.

Top module: `serclk_gen`

## Requirements
- R1: While reset (rst_n low) is held, os_tick, bit_tick, xfer_clk_out and xfer_clk_oe are all 0.
- R2: In asynchronous mode (sync_sel=0), os_tick is a one-cycle pulse that repeats every baud_div+1 cycles. The first pulse is registered on the first rising clock edge after reset is released.
- R3: In asynchronous normal mode (dbl_speed=0), bit_tick pulses together with the 16th, 32nd, ... os_tick after reset, and at no other time.
- R4: In asynchronous double-speed mode (dbl_speed=1), bit_tick pulses together with every 8th os_tick, and at no other time.
- R5: In master synchronous mode (sync_sel=1, clk_is_master=1), xfer_clk_out toggles every baud_div+1 cycles. It first goes high on the first edge after reset. bit_tick pulses in the cycle where xfer_clk_out has just risen, and os_tick pulses in the cycle where it has just fallen.
- R6: dbl_speed has no effect on any output in either synchronous mode.
- R7: xfer_clk_oe is 1 exactly when sync_sel=1 and clk_is_master=1. Whenever xfer_clk_oe is 0, xfer_clk_out is 0.
- R8: In slave synchronous mode (sync_sel=1, clk_is_master=0), a rising edge on xfer_clk_in gives a one-cycle bit_tick and a falling edge gives a one-cycle os_tick. Each pulse is registered on the third rising clock edge after the pin changes. baud_div has no effect in this mode. The pin must stay in each level for at least 4 clock cycles.
- R9: With baud_div=0 in asynchronous mode, os_tick is high on every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | 12 | Divider reload value; divider period is baud_div+1 cycles |
| sync_sel | input | 1 | 1 = synchronous operation, 0 = asynchronous |
| dbl_speed | input | 1 | Asynchronous only: 1 = 8x oversampling, 0 = 16x |
| clk_is_master | input | 1 | Synchronous only: 1 = drive transfer clock, 0 = receive it |
| xfer_clk_in | input | 1 | External transfer clock (slave mode) |
| os_tick | output | 1 | Receiver oversample / sample-edge pulse |
| bit_tick | output | 1 | Transmitter bit pulse |
| xfer_clk_out | output | 1 | Transfer clock driven in master mode |
| xfer_clk_oe | output | 1 | Output enable for the transfer clock pin |

## Verification
All outputs are registered. The divider-driven pulses therefore appear on edge 1 + k·(baud_div+1) after reset release. This holds for os_tick and bit_tick in the asynchronous modes, and for the toggles of xfer_clk_out in master mode. A slave pulse appears three edges after the pin change: two edges of synchronizer and one output register. The driver converts each stimulus into a list of expected (cycle, pulse kind) entries using these formulas. The monitor reads the outputs on the falling edge, counts edges from reset release, and compares each pulse it sees against the head of that list. Any missing, late or extra pulse is reported.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC_NORM  = 2'd0,
        MODE_ASYNC_DBL   = 2'd1,
        MODE_SYNC_MASTER = 2'd2,
        MODE_SYNC_SLAVE  = 2'd3
    } serclk_mode_e;

    // Double-speed only matters without sync; direction only matters with sync.
    function automatic serclk_mode_e decode_mode(input logic sync_sel,
                                                 input logic dbl,
                                                 input logic master);
        serclk_mode_e m;
        if (sync_sel) m = master ? MODE_SYNC_MASTER : MODE_SYNC_SLAVE;
        else          m = dbl    ? MODE_ASYNC_DBL   : MODE_ASYNC_NORM;
        return m;
    endfunction

    typedef struct packed {
        logic os_tick;
        logic bit_tick;
        logic xclk;
        logic oe;
    } serclk_out_t;

endpackage

// File: rtl/serclk_divider.sv
module serclk_divider #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             hit
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == '0) st_d.cnt = div_val;
        else                st_d.cnt = st_q.cnt - ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit = (st_q.cnt == '0);
endmodule

// File: rtl/serclk_prescale.sv
module serclk_prescale #(
    parameter int RATIO_NORM = 16,
    parameter int RATIO_DBL  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic dbl,
    input  logic hit,
    output logic last
);
    localparam int CW = $clog2(RATIO_NORM);
    localparam logic [CW-1:0] TOP_NORM = CW'(RATIO_NORM - 1);
    localparam logic [CW-1:0] TOP_DBL  = CW'(RATIO_DBL - 1);
    localparam logic [CW-1:0] ONE      = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ps_st_t;

    ps_st_t st_d, st_q;
    logic [CW-1:0] top;
    logic          at_top;

    always_comb begin
        top    = dbl ? TOP_DBL : TOP_NORM;
        at_top = (st_q.cnt >= top);
        st_d   = st_q;
        if (!en)      st_d.cnt = '0;
        else if (hit) st_d.cnt = at_top ? '0 : st_q.cnt + ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign last = en & hit & at_top;
endmodule

// File: rtl/serclk_edge_sync.sv
module serclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int W = STAGES + 1;

    typedef struct packed {
        logic [W-1:0] pipe;
    } es_st_t;

    es_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[W-2:0], pin};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise =  st_q.pipe[W-2] & ~st_q.pipe[W-1];
    assign fall = ~st_q.pipe[W-2] &  st_q.pipe[W-1];
endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
    import serclk_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int OS_NORM     = 16,
    parameter int OS_DBL      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] baud_div,
    input  logic             sync_sel,
    input  logic             dbl_speed,
    input  logic             clk_is_master,
    input  logic             xfer_clk_in,
    output logic             os_tick,
    output logic             bit_tick,
    output logic             xfer_clk_out,
    output logic             xfer_clk_oe
);
    serclk_mode_e mode;
    logic         hit, ps_last, ext_rise, ext_fall, async_en;
    serclk_out_t  st_d, st_q;

    assign mode     = decode_mode(sync_sel, dbl_speed, clk_is_master);
    assign async_en = (mode == MODE_ASYNC_NORM) || (mode == MODE_ASYNC_DBL);

    serclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div_val(baud_div), .hit(hit)
    );

    serclk_prescale #(.RATIO_NORM(OS_NORM), .RATIO_DBL(OS_DBL)) u_ps (
        .clk(clk), .rst_n(rst_n), .en(async_en),
        .dbl(mode == MODE_ASYNC_DBL), .hit(hit), .last(ps_last)
    );

    serclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(xfer_clk_in),
        .rise(ext_rise), .fall(ext_fall)
    );

    always_comb begin
        st_d          = st_q;
        st_d.os_tick  = 1'b0;
        st_d.bit_tick = 1'b0;
        st_d.xclk     = 1'b0;
        st_d.oe       = (mode == MODE_SYNC_MASTER);
        unique case (mode)
            MODE_ASYNC_NORM, MODE_ASYNC_DBL: begin
                st_d.os_tick  = hit;
                st_d.bit_tick = ps_last;
            end
            MODE_SYNC_MASTER: begin
                st_d.xclk = hit ? ~st_q.xclk : st_q.xclk;
                // launch edge on the rise, sample edge on the fall
                st_d.bit_tick = hit & ~st_q.xclk;
                st_d.os_tick  = hit &  st_q.xclk;
            end
            MODE_SYNC_SLAVE: begin
                st_d.bit_tick = ext_rise;
                st_d.os_tick  = ext_fall;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign os_tick      = st_q.os_tick;
    assign bit_tick     = st_q.bit_tick;
    assign xfer_clk_out = st_q.xclk;
    assign xfer_clk_oe  = st_q.oe;
endmodule

// File: rtl/serclk_gen_chk.sv
module serclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic sync_sel,
    input logic os_tick,
    input logic bit_tick,
    input logic xfer_clk_out,
    input logic xfer_clk_oe
);
    // R3/R4: a bit tick in async operation always coincides with an oversample tick
    a_r3_bit_on_os: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !$past(sync_sel)) |-> os_tick);

    // R5: the rising transfer clock carries the bit tick
    a_r5_rise_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_clk_out) |-> bit_tick);

    // R5: a falling transfer clock while still driving carries the sample tick
    a_r5_fall_os: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(xfer_clk_out) && xfer_clk_oe) |-> os_tick);

    // R7: pin not driven implies level held low
    a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_clk_oe |-> !xfer_clk_out);

    // R8: in synchronous modes the two pulses never coincide
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sync_sel) |-> !(bit_tick && os_tick));

    // R8: bit pulses last exactly one cycle
    a_r8_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);
endmodule

bind serclk_gen serclk_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sync_sel(sync_sel),
    .os_tick(os_tick), .bit_tick(bit_tick),
    .xfer_clk_out(xfer_clk_out), .xfer_clk_oe(xfer_clk_oe)
);

// File: tb/serclk_gen_test.sv
module serclk_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] baud_div = '0;
    logic        sync_sel = 1'b0, dbl_speed = 1'b0, clk_is_master = 1'b0;
    logic        xfer_clk_in = 1'b0;
    logic        os_tick, bit_tick, xfer_clk_out, xfer_clk_oe;

    int n_chk = 0, n_fail = 0, cyc = 0, win_end = 0, cur_div = 0;
    logic active = 1'b0, chk_xclk = 1'b0;
    int exp_q[$];

    always #5 clk = ~clk;

    serclk_gen uut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .sync_sel(sync_sel),
        .dbl_speed(dbl_speed), .clk_is_master(clk_is_master),
        .xfer_clk_in(xfer_clk_in), .os_tick(os_tick), .bit_tick(bit_tick),
        .xfer_clk_out(xfer_clk_out), .xfer_clk_oe(xfer_clk_oe)
    );

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // code = cycle*4 + kind, kind 1 = os_tick, 2 = bit_tick
    task automatic pop_cmp(input int code);
        n_chk++;
        if (exp_q.size() != 0 && exp_q[0] == code) void'(exp_q.pop_front());
        else begin
            n_fail++;
            $display("FAIL R2-R9 pulse: actual cyc %0d kind %0d expected code %0d",
                     code / 4, code % 4, (exp_q.size() != 0) ? exp_q[0] : -1);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (active && rst_n && cyc >= 1 && cyc <= win_end) begin
            if (os_tick)  pop_cmp(cyc * 4 + 1);
            if (bit_tick) pop_cmp(cyc * 4 + 2);
            if (chk_xclk && ((cyc - 1) % (cur_div + 1) == 0))
                check("R5 xclk level", int'(xfer_clk_out),
                      (((cyc - 1) / (cur_div + 1)) % 2 == 0) ? 1 : 0);
        end
    end

    task automatic start(input logic s, input logic d, input logic m, input int div);
        active = 1'b0; chk_xclk = 1'b0;
        exp_q.delete();
        rst_n = 1'b0;
        sync_sel = s; dbl_speed = d; clk_is_master = m;
        baud_div = 12'(div); cur_div = div; xfer_clk_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 os_tick reset", int'(os_tick), 0);
        check("R1 bit_tick reset", int'(bit_tick), 0);
        check("R1 xclk reset", int'(xfer_clk_out), 0);
        check("R1 oe reset", int'(xfer_clk_oe), 0);
        rst_n = 1'b1;
    endtask

    task automatic push_async(input int div, input int ratio, input int win);
        for (int k = 0; 1 + k * (div + 1) <= win; k++) begin
            exp_q.push_back((1 + k * (div + 1)) * 4 + 1);
            if (k % ratio == ratio - 1) exp_q.push_back((1 + k * (div + 1)) * 4 + 2);
        end
    endtask

    task automatic push_master(input int div, input int win);
        for (int k = 0; 1 + k * (div + 1) <= win; k++)
            exp_q.push_back((1 + k * (div + 1)) * 4 + ((k % 2 == 0) ? 2 : 1));
    endtask

    task automatic finish_window(input string req);
        while (cyc <= win_end) @(negedge clk);
        active = 1'b0;
        check(req, exp_q.size(), 0);
    endtask

    initial begin
        // R2, R3: normal async, divisor 3
        start(1'b0, 1'b0, 1'b1, 3);
        win_end = 140; push_async(3, 16, 140); active = 1'b1;
        finish_window("R3 leftover");
        check("R7 oe async", int'(xfer_clk_oe), 0);
        check("R7 xclk async", int'(xfer_clk_out), 0);

        // R4: double speed, divisor 2
        start(1'b0, 1'b1, 1'b0, 2);
        win_end = 100; push_async(2, 8, 100); active = 1'b1;
        finish_window("R4 leftover");

        // R9: divisor 0, tick every cycle
        start(1'b0, 1'b0, 1'b0, 0);
        win_end = 40; push_async(0, 16, 40); active = 1'b1;
        finish_window("R9 leftover");

        // R5: master, divisor 4
        start(1'b1, 1'b0, 1'b1, 4);
        win_end = 60; push_master(4, 60); active = 1'b1; chk_xclk = 1'b1;
        finish_window("R5 leftover");
        check("R7 oe master", int'(xfer_clk_oe), 1);

        // R6: master with double speed set, same timing
        start(1'b1, 1'b1, 1'b1, 4);
        win_end = 60; push_master(4, 60); active = 1'b1; chk_xclk = 1'b1;
        finish_window("R6 leftover");

        // R8: slave, divisor must not matter; R6 dbl set too
        start(1'b1, 1'b1, 1'b0, 5);
        win_end = 100; active = 1'b1;
        for (int i = 0; i < 8; i++) begin
            while (cyc < 10 + 8 * i) @(negedge clk);
            xfer_clk_in = ~xfer_clk_in;
            exp_q.push_back((cyc + 3) * 4 + (xfer_clk_in ? 2 : 1));
        end
        finish_window("R8 leftover");
        check("R7 oe slave", int'(xfer_clk_oe), 0);
        check("R7 xclk slave", int'(xfer_clk_out), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule